// File: doc/BRIEF.md
# Three-Slot VLIW Processing Element

This block is one compute tile for a mesh of processing elements. Each instruction word issues up to three operations at once: one to a multiplier, one to an adder/logic unit and one to a shifter. Every slot picks two source registers and one destination register from a single 32-entry register space. Input ports feed the lowest entries of that space, the next entries drive the output ports, and the rest are general-purpose registers. Two flags, one for zero and one for carry, are set from the adder slot. They steer a conditional jump that is coded in the same word.

A local program store holds sixteen 76-bit words. While `run` is low, a host fills the store through a plain write port. Nothing executes while `run` is low. While `run` is high, one word executes per clock. The program counter wraps from 15 to 0 unless a jump is taken.

Top module: `vliw_pe`

## Requirements
- R1: While `rst_n` is low, all 32 registers, both flags and `pc` clear to zero, so `out_data` and `pc` read 0.
- R2: Register addresses 0 and 1 are the input registers. Address k takes `in_data[32k+31:32k]` on every clock edge where `in_valid[k]` is 1, whether or not `run` is high, and keeps its value otherwise. A slot that names address 0 or 1 as its destination writes nothing.
- R3: Register address 2 drives `out_data[31:0]` and address 3 drives `out_data[63:32]`, continuously.
- R4: Addresses 4 to 31 are general-purpose registers. Any slot may read any of the 32 addresses.
- R5: A word is {ctrl[75:72], shift slot[71:48], add slot[47:24], multiply slot[23:0]}. Each slot is {en[23], op[22:20], dst[19:15], srcA[14:10], srcB[9:5], aux[4:0]}. The multiply slot writes the low 32 bits of the unsigned product A*B when op[0] is 0, and the high 32 bits when op[0] is 1.
- R6: The add slot computes, by op: 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 A. Ops 6 and 7 act as A+B.
- R7: The shift slot shifts A by B[4:0], by op: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate left. Ops 4 to 7 act as logical left.
- R8: All slots of a word read their sources before any slot of that word writes back.
- R9: If several enabled slots name the same destination, the shift slot wins over the add slot, and the add slot wins over the multiply slot. A slot with en=0 writes nothing.
- R10: When the add slot is enabled and ctrl[74] is 1, f0 takes (add result == 0). When the add slot is enabled and ctrl[75] is 1, f1 takes the carry out of the add slot: for op 1 this is the carry of A + ~B + 1, and for logic ops it is 0. In every other case the flags hold.
- R11: When `run` is high and no jump is taken, `pc` advances by one and wraps from 15 to 0. When `run` is low, `pc`, the flags and all registers except the input registers hold.
- R12: ctrl[73:72] selects the jump: 00 never, 01 if f0, 10 if f1, 11 always. The flags tested are the values from before this word executes. A taken jump loads `pc` with word bits [3:0].
- R13: A clock edge with `im_we` high writes `im_wdata` into program word `im_addr`. The word at `pc` is read combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute one word per clock while high |
| im_we | input | 1 | Program store write enable |
| im_addr | input | 4 | Program store write address |
| im_wdata | input | 76 | Program word to write |
| in_valid | input | 2 | Per-port load strobe for the input registers |
| in_data | input | 64 | Input port data, port k in bits [32k+31:32k] |
| out_data | output | 64 | Output register contents, port k in bits [32k+31:32k] |
| pc | output | 4 | Program counter |

## Verification
Small operands such as 6 and 7 give distinct sums, products and shifts, so a wrong operand route or a swapped slot shows up as a wrong value. Large operands with the top bit set separate the high from the low product half, the arithmetic from the logical right shift, and rotation from plain shifting. They also produce a real carry out. Words whose slots share a destination, or read a register that another slot of the same word writes, tell write priority and read-before-write apart. Sequences of jump words that test a flag set by the previous word or by the same word show which flag values the jump uses. They also show whether a disabled adder slot can touch the flags.

// File: rtl/vliw_pe.sv
module vliw_pe #(
  parameter int DW     = 32,
  parameter int NIN    = 2,
  parameter int NOUT   = 2,
  parameter int IDEPTH = 16,
  localparam int PCW   = $clog2(IDEPTH),
  localparam int SW    = 24,
  localparam int IW    = 3 * SW + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 im_we,
  input  logic [PCW-1:0]       im_addr,
  input  logic [IW-1:0]        im_wdata,
  input  logic [NIN-1:0]       in_valid,
  input  logic [NIN*DW-1:0]    in_data,
  output logic [NOUT*DW-1:0]   out_data,
  output logic [PCW-1:0]       pc
);

  localparam int AW   = 5;
  localparam int NREG = 1 << AW;
  localparam int SHW  = $clog2(DW);

  logic [IW-1:0] imem [IDEPTH];
  logic [DW-1:0] rf [NREG];
  logic          f0, f1;

  logic [IW-1:0] iw;
  logic [3:0]    ctrl;
  logic          taken;

  logic          en  [3];
  logic [2:0]    op  [3];
  logic [AW-1:0] dst [3];
  logic [DW-1:0] va  [3];
  logic [DW-1:0] vb  [3];
  logic [DW-1:0] res [3];

  logic [2*DW-1:0] prod;
  logic [DW:0]     addw;
  logic [SHW-1:0]  amt;

  assign iw   = imem[pc];
  assign ctrl = iw[IW-1 -: 4];

  for (genvar s = 0; s < 3; s++) begin : g_dec
    assign en[s]  = iw[s*SW + 23];
    assign op[s]  = iw[s*SW + 20 +: 3];
    assign dst[s] = iw[s*SW + 15 +: AW];
    assign va[s]  = rf[iw[s*SW + 10 +: AW]];
    assign vb[s]  = rf[iw[s*SW + 5 +: AW]];
  end

  assign prod   = {{DW{1'b0}}, va[0]} * {{DW{1'b0}}, vb[0]};
  assign res[0] = op[0][0] ? prod[2*DW-1:DW] : prod[DW-1:0];

  always_comb begin
    addw = {1'b0, va[1]} + {1'b0, vb[1]};
    case (op[1])
      3'd1:    addw = {1'b0, va[1]} + {1'b0, ~vb[1]} + {{DW{1'b0}}, 1'b1};
      3'd2:    addw = {1'b0, va[1] & vb[1]};
      3'd3:    addw = {1'b0, va[1] | vb[1]};
      3'd4:    addw = {1'b0, va[1] ^ vb[1]};
      3'd5:    addw = {1'b0, va[1]};
      default: ;
    endcase
  end
  assign res[1] = addw[DW-1:0];

  assign amt = vb[2][SHW-1:0];
  always_comb begin
    case (op[2])
      3'd1:    res[2] = va[2] >> amt;
      3'd2:    res[2] = DW'($signed(va[2]) >>> amt);
      3'd3:    res[2] = (va[2] << amt) | (va[2] >> (DW - int'(amt)));
      default: res[2] = va[2] << amt;
    endcase
  end

  assign taken = (ctrl[1:0] == 2'b11) || (ctrl[1:0] == 2'b01 && f0) ||
                 (ctrl[1:0] == 2'b10 && f1);

  always_ff @(posedge clk)
    if (im_we) imem[im_addr] <= im_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      pc <= '0;
      f0 <= 1'b0;
      f1 <= 1'b0;
    end else begin
      for (int i = 0; i < NIN; i++)
        if (in_valid[i]) rf[i] <= in_data[i*DW +: DW];
      if (run) begin
        for (int s = 0; s < 3; s++)
          if (en[s] && dst[s] >= AW'(NIN)) rf[dst[s]] <= res[s];
        if (en[1] && ctrl[2]) f0 <= (res[1] == '0);
        if (en[1] && ctrl[3]) f1 <= addw[DW];
        pc <= taken ? iw[PCW-1:0] : PCW'(pc + 1'b1);
      end
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    assign out_data[o*DW +: DW] = rf[NIN + o];
  end

  a_r11_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !taken |=> pc == PCW'($past(pc) + 1'b1));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc) && $stable(f0) && $stable(f1));

  a_r12_jump: assert property (@(posedge clk) disable iff (!rst_n)
    run && taken |=> pc == $past(iw[PCW-1:0]));

  a_r10_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !en[1] |=> $stable(f0) && $stable(f1));

  for (genvar i = 0; i < NIN; i++) begin : g_chk
    a_r2_in_load: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[i] |=> rf[i] == $past(in_data[i*DW +: DW]));
    a_r2_in_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[i] |=> $stable(rf[i]));
  end

endmodule

// File: tb/test_vliw_pe.sv
`timescale 1ns/1ps
module test_vliw_pe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        im_we = 1'b0;
  logic [3:0]  im_addr = '0;
  logic [75:0] im_wdata = '0;
  logic [1:0]  in_valid = '0;
  logic [63:0] in_data = '0;
  logic [63:0] out_data;
  logic [3:0]  pc;

  always #2 clk = ~clk;

  vliw_pe i_vliw_pe (.clk(clk), .rst_n(rst_n), .run(run), .im_we(im_we),
    .im_addr(im_addr), .im_wdata(im_wdata), .in_valid(in_valid),
    .in_data(in_data), .out_data(out_data), .pc(pc));

  typedef struct packed { logic [31:0] o1; logic [31:0] o0; logic [3:0] p; } exp_t;
  exp_t  q[$];
  string rq[$];
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] e0 = 0, e1 = 0;
  logic [3:0]  pcm = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      string r;
      e = q.pop_front();
      r = rq.pop_front();
      nchk++;
      if (out_data !== {e.o1, e.o0} || pc !== e.p) begin
        nfail++;
        $display("FAIL %s: out=%h pc=%0d expected out=%h pc=%0d",
                 r, out_data, pc, {e.o1, e.o0}, e.p);
      end
    end
  end

  function automatic logic [23:0] sl(bit en, logic [2:0] op, logic [4:0] d,
                                     logic [4:0] a, logic [4:0] b, logic [4:0] aux = 5'd0);
    return {en, op, d, a, b, aux};
  endfunction

  function automatic logic [75:0] wd(logic [23:0] m, logic [23:0] a,
                                     logic [23:0] s, logic [3:0] c);
    return {c, s, a, m};
  endfunction

  function automatic logic [31:0] rotl(logic [31:0] v, int n);
    for (int k = 0; k < n; k++) v = {v[30:0], v[31]};
    return v;
  endfunction

  task automatic push(string r);
    q.push_back('{o1: e1, o0: e0, p: pcm});
    rq.push_back(r);
  endtask

  task automatic exec(logic [75:0] w, logic [3:0] np, string r);
    @(negedge clk); im_we = 1; im_addr = pcm; im_wdata = w;
    @(negedge clk); im_we = 0; run = 1;
    @(posedge clk); #1; pcm = np; push(r);
    @(negedge clk); run = 0;
  endtask

  task automatic idle(string r);
    @(negedge clk); run = 0;
    @(posedge clk); #1; push(r);
  endtask

  task automatic load_in(logic [1:0] v, logic [31:0] d0, logic [31:0] d1);
    @(negedge clk); in_valid = v; in_data = {d1, d0};
    @(negedge clk); in_valid = 0;
  endtask

  localparam logic [23:0] NOP = 24'd0;
  logic [31:0] a, b;
  logic [63:0] p64;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    push("R1 reset state");
    load_in(2'b11, 32'd6, 32'd7);
    idle("R11 idle after input load");
    e0 = 13; e1 = 42;
    exec(wd(sl(1,0,3,0,1), sl(1,0,2,0,1), NOP, 4'd0), 4'd1, "R5 mul R6 add R3 out");
    exec(wd(sl(1,0,5,1,1), sl(1,5,4,0,0), sl(1,0,6,0,1), 4'd0), 4'd2, "R4 gp write");
    e0 = 768; e1 = 49;
    exec(wd(NOP, sl(1,5,2,6,0), sl(1,0,3,5,7), 4'd0), 4'd3, "R7 sll R4 gp read");
    e0 = 6;
    exec(wd(NOP, sl(1,0,4,4,1), sl(1,0,2,4,7), 4'd0), 4'd4, "R8 read before write");
    e1 = 13;
    exec(wd(NOP, sl(1,5,3,4,0), NOP, 4'd0), 4'd5, "R8 later value");
    e0 = 7;
    exec(wd(sl(1,0,2,0,1), sl(1,0,2,0,1), sl(1,0,2,1,7), 4'd0), 4'd6, "R9 shift wins");
    e1 = 1;
    exec(wd(sl(1,0,3,0,1), sl(1,1,3,1,0), NOP, 4'd0), 4'd7, "R9 add over mul");
    exec(wd(sl(0,0,2,0,1), sl(0,0,2,0,1), sl(0,0,2,0,1), 4'd0), 4'd8, "R9 disabled slots");
    exec(wd(sl(1,0,1,0,0), sl(1,0,0,1,1), NOP, 4'd0), 4'd9, "R2 write input addr");
    e0 = 6; e1 = 7;
    exec(wd(NOP, sl(1,5,2,0,0), sl(1,0,3,1,7), 4'd0), 4'd10, "R2 input regs kept");
    load_in(2'b01, 32'd100, 32'd999);
    e0 = 107;
    exec(wd(NOP, sl(1,0,2,0,1), NOP, 4'd0), 4'd11, "R2 per-port valid");
    a = 32'hF0F0_1234; b = 32'h0FF0_FFFF;
    load_in(2'b11, a, b);
    p64 = 64'(a) * 64'(b);
    e0 = a & b; e1 = p64[63:32];
    exec(wd(sl(1,1,3,0,1), sl(1,2,2,0,1), NOP, 4'd0), 4'd12, "R6 and R5 mul high");
    e0 = a ^ b; e1 = 32'hFFFF_FFFF;
    exec(wd(NOP, sl(1,4,2,0,1), sl(1,2,3,0,1), 4'd0), 4'd13, "R6 xor R7 sra");
    e0 = a | b; e1 = rotl(a, 31);
    exec(wd(NOP, sl(1,3,2,0,1), sl(1,3,3,0,1), 4'd0), 4'd14, "R6 or R7 rotl");
    e0 = a - b; e1 = b >> 20;
    exec(wd(NOP, sl(1,1,2,0,1), sl(1,1,3,1,0), 4'd0), 4'd15, "R6 sub R7 srl");
    e0 = a + b; e1 = p64[31:0];
    exec(wd(sl(1,0,3,0,1), sl(1,0,2,0,1), NOP, 4'd0), 4'd0, "R11 wrap R6 add R5 mul low");
    exec(wd(NOP, sl(1,1,4,0,0), NOP, 4'b0100), 4'd1, "R10 zero flag set");
    exec(wd(sl(0,0,0,0,0,5'd9), NOP, NOP, 4'b0001), 4'd9, "R12 jump on f0");
    exec(wd(sl(0,0,0,0,0,5'd2), NOP, NOP, 4'b0010), 4'd10, "R10 f1 untouched");
    exec(wd(sl(0,0,0,0,0,5'd3), sl(1,0,4,0,0), NOP, 4'b1101), 4'd3, "R12 old flags used");
    exec(wd(sl(0,0,0,0,0,5'd12), NOP, NOP, 4'b0001), 4'd4, "R10 f0 cleared");
    exec(wd(sl(0,0,0,0,0,5'd15), NOP, NOP, 4'b0010), 4'd15, "R10 carry set R12");
    exec(wd(sl(0,0,0,0,0,5'd6), sl(0,1,4,0,0), NOP, 4'b0111), 4'd6, "R12 always jump");
    exec(wd(sl(0,0,0,0,0,5'd1), NOP, NOP, 4'b0001), 4'd7, "R10 disabled add keeps f0");
    @(negedge clk); im_we = 1; im_addr = 4'd7; im_wdata = '1;
    @(negedge clk); im_we = 0;
    idle("R13 write while stopped");
    idle("R11 hold");
    e0 = 32'd55;
    exec(wd(NOP, sl(1,5,2,0,0), NOP, 4'd0), 4'd8, "R13 rewritten word runs");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    wait (pcm == 4'd7 && im_we === 1'b1 && im_wdata === '1);
    @(negedge clk);
    in_valid = 2'b01; in_data = {32'd0, 32'd55};
    @(negedge clk); in_valid = 0;
  end
endmodule